// File: doc/BRIEF.md
# Line Latch with Polarity-Steered Gray-Level Outputs

This block sits between the sampling register of a column driver and its per-channel output stage. The sampling logic fills a parallel line bus with one 6-bit gray code per channel. A line strobe then hands that line over to the output side, so the next line can be sampled while the current one is displayed. On the strobe's rising edge the line bus is copied into an internal line latch and the polarity input is captured. While the strobe stays high, every channel output is released to high impedance. On the falling edge the latched line and its polarity move to the channel output registers, and the outputs drive again.

Each channel presents four things: its registered code; a flag that picks the upper or the lower set of five reference levels; a segment index with an in-segment step that names the pair of references the level lies between; and the absolute number (0 to 9) of the segment's starting reference. Neighbouring channels always take opposite sets, and the polarity input chooses which arrangement applies. The line bus is framed by the strobe alone and has no valid/ready handshake. Data is taken only at the strobe's rising edge, so the bus never sees back-pressure. The source must hold the line stable at that edge and should send one strobe pulse per display line.

Top module: `line_latch_drv`

## Requirements
- R1: After reset, drive_en is all zero and every ch_code is zero. They stay that way until a complete strobe pulse (a low-to-high transition seen after reset, then a fall) has occurred. A strobe that is already high during reset and falls after release does not enable the outputs.
- R2: The line presented after a strobe pulse equals the line_data value at the clock edge where the strobe's rise was seen. Later changes to line_data while the strobe is high do not alter that line.
- R3: From the clock edge that sees the strobe rise until the edge that sees it fall, drive_en is all zero.
- R4: At the clock edge that sees the strobe fall after a captured rise, drive_en becomes all ones and ch_code takes the latched line. Between that edge and the next strobe pulse, ch_code and ch_lower hold, whatever line_data and polarity do.
- R5: Polarity is captured at the strobe rise. Channel index 0 is the first output. Even-index channels get ch_lower equal to the captured polarity. Odd-index channels get its inverse. ch_lower = 1 selects the lower reference set.
- R6: For a code below 3Fh, ch_seg = code[5:4] and ch_step = code[3:0]. Code 3Fh gives ch_seg = 4 and ch_step = 0, which is the end reference of the last segment.
- R7: With ch_lower = 0, ch_ref = ch_seg. With ch_lower = 1, ch_ref = 9 - ch_seg. So in the lower set, 00h maps to 9 and 10h, 20h, 30h and 3Fh map to 8, 7, 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_data | input | NCH*CODE_W | Sampled line, channel i at bits [i*CODE_W +: CODE_W] |
| strobe | input | 1 | Line strobe: rise latches, high holds off, fall drives |
| polarity | input | 1 | Reference-set arrangement, captured at strobe rise |
| drive_en | output | NCH | Per-channel drive enable (0 = high impedance) |
| ch_code | output | NCH*CODE_W | Registered per-channel gray code |
| ch_lower | output | NCH | 1 = lower reference set, 0 = upper |
| ch_seg | output | NCH*3 | Segment index 0..4 |
| ch_step | output | NCH*(CODE_W-2) | Step within segment |
| ch_ref | output | NCH*4 | Absolute starting reference number 0..9 |

## Verification
One line places boundary codes (00h, 0Fh, 10h, 1Fh, 20h, 30h, 3Eh, 3Fh) across the channels. It is sent under both polarities, which separates the segment split and the end-point case from the mirrored reference numbering. Uniform lines of all 3Fh and all 00h catch a swap between the two sets or an error in the 9 - seg mapping. A line whose data and polarity are inverted while the strobe is high shows whether capture happens at the rise or later. Random lines with varied strobe widths and idle gaps, with the inputs disturbed between pulses, show that output updates are tied to the fall and that nothing else changes them.

// File: rtl/llat_pkg.sv
package llat_pkg;
  // Strobe handling phase
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0, // after reset, no rise seen yet
    PH_HOLD = 2'd1, // rise captured, outputs off
    PH_SHOW = 2'd2  // latched line on the outputs
  } phase_t;
endpackage

// File: rtl/llat_strobe_ctl.sv
module llat_strobe_ctl
  import llat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic cap_en,
  output logic load_en,
  output logic drive
);
  phase_t ph_q, ph_d;
  logic   stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      stb_q <= 1'b1; // a strobe already high at reset is not a rise
    end else begin
      ph_q  <= ph_d;
      stb_q <= strobe;
    end
  end

  always_comb begin
    cap_en  = strobe & ~stb_q;
    load_en = (ph_q == PH_HOLD) & ~strobe;
    ph_d    = ph_q;
    if (cap_en)       ph_d = PH_HOLD;
    else if (load_en) ph_d = PH_SHOW;
  end

  assign drive = (ph_q == PH_SHOW);
endmodule

// File: rtl/llat_level_split.sv
module llat_level_split #(
  parameter int CODE_W = 6,
  parameter int SEG_W  = 2
) (
  input  logic [CODE_W-1:0]                 code,
  input  logic                              lower,
  output logic [$clog2((1<<SEG_W)+1)-1:0]   seg,
  output logic [CODE_W-SEG_W-1:0]           step,
  output logic [$clog2(2*((1<<SEG_W)+1))-1:0] ref_num
);
  localparam int NSEG   = 1 << SEG_W;
  localparam int SEGI_W = $clog2(NSEG + 1);
  localparam int STEP_W = CODE_W - SEG_W;
  localparam int REF_W  = $clog2(2 * (NSEG + 1));
  localparam logic [REF_W-1:0] REF_TOP = REF_W'(2 * NSEG + 1);

  logic at_end;
  assign at_end = &code;

  always_comb begin
    if (at_end) begin
      seg  = SEGI_W'(NSEG);
      step = '0;
    end else begin
      seg  = SEGI_W'(code[CODE_W-1 -: SEG_W]);
      step = code[STEP_W-1:0];
    end
    ref_num = lower ? (REF_TOP - REF_W'(seg)) : REF_W'(seg);
  end
endmodule

// File: rtl/line_latch_drv.sv
module line_latch_drv #(
  parameter int NCH    = 8,
  parameter int CODE_W = 6,
  parameter int SEG_W  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH*CODE_W-1:0]       line_data,
  input  logic                        strobe,
  input  logic                        polarity,
  output logic [NCH-1:0]              drive_en,
  output logic [NCH*CODE_W-1:0]       ch_code,
  output logic [NCH-1:0]              ch_lower,
  output logic [NCH*3-1:0]            ch_seg,
  output logic [NCH*(CODE_W-2)-1:0]   ch_step,
  output logic [NCH*4-1:0]            ch_ref
);
  localparam int NSEG   = 1 << SEG_W;
  localparam int SEGI_W = $clog2(NSEG + 1);
  localparam int STEP_W = CODE_W - SEG_W;
  localparam int REF_W  = $clog2(2 * (NSEG + 1));

  logic cap_en, load_en, drive;
  logic pol_cap_q, pol_out_q;

  llat_strobe_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .cap_en  (cap_en),
    .load_en (load_en),
    .drive   (drive)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_cap_q <= 1'b0;
      pol_out_q <= 1'b0;
    end else begin
      if (cap_en)  pol_cap_q <= polarity;
      if (load_en) pol_out_q <= pol_cap_q;
    end
  end

  assign drive_en = {NCH{drive}};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CODE_W-1:0] latch_q, out_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latch_q <= '0;
        out_q   <= '0;
      end else begin
        if (cap_en)  latch_q <= line_data[i*CODE_W +: CODE_W];
        if (load_en) out_q   <= latch_q;
      end
    end

    // neighbours alternate between the two reference sets
    logic lower;
    if (i % 2 == 0) begin : g_even
      assign lower = pol_out_q;
    end else begin : g_odd
      assign lower = ~pol_out_q;
    end

    logic [SEGI_W-1:0] seg;
    logic [STEP_W-1:0] step;
    logic [REF_W-1:0]  ref_num;

    llat_level_split #(.CODE_W(CODE_W), .SEG_W(SEG_W)) u_split (
      .code    (out_q),
      .lower   (lower),
      .seg     (seg),
      .step    (step),
      .ref_num (ref_num)
    );

    assign ch_code[i*CODE_W +: CODE_W] = out_q;
    assign ch_lower[i]                 = lower;
    assign ch_seg[i*3 +: 3]            = 3'(seg);
    assign ch_step[i*STEP_W +: STEP_W] = step;
    assign ch_ref[i*4 +: 4]            = 4'(ref_num);
  end
endmodule

// File: rtl/line_latch_drv_chk.sv
module line_latch_drv_chk #(
  parameter int NCH    = 8,
  parameter int CODE_W = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      strobe,
  input logic [NCH-1:0]            drive_en,
  input logic [NCH*CODE_W-1:0]     ch_code,
  input logic [NCH-1:0]            ch_lower,
  input logic [NCH*3-1:0]          ch_seg,
  input logic [NCH*(CODE_W-2)-1:0] ch_step,
  input logic [NCH*4-1:0]          ch_ref
);
  logic stb_prev, seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_prev <= 1'b1;
      seen     <= 1'b0;
    end else begin
      stb_prev <= strobe;
      seen     <= seen | (strobe & ~stb_prev);
    end
  end

  // R1
  no_early_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> drive_en == '0);

  // R3
  hiz_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe) |-> drive_en == '0);

  // R4
  fall_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(strobe) && !strobe) |=> &drive_en);

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$past(strobe) && $past(strobe, 2)) |-> $stable(ch_code));

  // R6
  end_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&ch_code[CODE_W-1:0]) |-> (ch_seg[2:0] == 3'd4 && ch_step[CODE_W-3:0] == '0));

  // R7
  ref_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_lower[0] ? (ch_ref[3:0] == 4'd9 - {1'b0, ch_seg[2:0]})
                : (ch_ref[3:0] == {1'b0, ch_seg[2:0]}));
endmodule

bind line_latch_drv line_latch_drv_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe   (strobe),
  .drive_en (drive_en),
  .ch_code  (ch_code),
  .ch_lower (ch_lower),
  .ch_seg   (ch_seg),
  .ch_step  (ch_step),
  .ch_ref   (ch_ref)
);

// File: tb/line_latch_drv_test.sv
`timescale 1ns/1ps
module line_latch_drv_test;
  localparam int NCH = 8;
  localparam int CW  = 6;
  localparam int LW  = NCH * CW;
  localparam int STW = CW - 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [LW-1:0]  line_data;
  logic           strobe;
  logic           polarity;
  logic [NCH-1:0] drive_en;
  logic [LW-1:0]  ch_code;
  logic [NCH-1:0] ch_lower;
  logic [NCH*3-1:0]   ch_seg;
  logic [NCH*STW-1:0] ch_step;
  logic [NCH*4-1:0]   ch_ref;

  always #2.5 clk = ~clk;

  line_latch_drv #(.NCH(NCH), .CODE_W(CW), .SEG_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .line_data(line_data), .strobe(strobe),
    .polarity(polarity), .drive_en(drive_en), .ch_code(ch_code),
    .ch_lower(ch_lower), .ch_seg(ch_seg), .ch_step(ch_step), .ch_ref(ch_ref)
  );

  typedef struct packed { logic [LW-1:0] codes; logic pol; } line_t;
  line_t exp_q[$];
  line_t it;
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int e_seg(input int code);
    return (code == 63) ? 4 : (code >> 4);
  endfunction
  function automatic int e_step(input int code);
    return (code == 63) ? 0 : (code & 15);
  endfunction

  // monitor: compare each newly presented line against the scoreboard
  logic prev_en;
  always @(negedge clk) begin
    if (!rst_n) prev_en = 1'b0;
    else begin
      if (drive_en[0] && !prev_en) begin
        chk(&drive_en, "R4 all channels driven", drive_en, {NCH{1'b1}});
        if (exp_q.size() == 0) chk(0, "R4 line without pulse", 1, 0);
        else begin
          it = exp_q.pop_front();
          for (int c = 0; c < NCH; c++) begin
            int code, lw, sg;
            code = int'(it.codes[c*CW +: CW]);
            lw   = int'(it.pol ^ c[0]);
            sg   = e_seg(code);
            chk(ch_code[c*CW +: CW] == CW'(code), "R2 code", ch_code[c*CW +: CW], code);
            chk(ch_lower[c] == lw[0], "R5 set select", ch_lower[c], lw);
            chk(ch_seg[c*3 +: 3] == 3'(sg), "R6 segment", ch_seg[c*3 +: 3], sg);
            chk(ch_step[c*STW +: STW] == STW'(e_step(code)), "R6 step",
                ch_step[c*STW +: STW], e_step(code));
            chk(ch_ref[c*4 +: 4] == 4'(lw ? 9 - sg : sg), "R7 reference number",
                ch_ref[c*4 +: 4], lw ? 9 - sg : sg);
          end
        end
      end
      prev_en = drive_en[0];
    end
  end

  line_t last;

  task automatic send_line(input logic [LW-1:0] d, input logic p, input int hi, input bit scramble);
    @(negedge clk);
    line_data = d; polarity = p; strobe = 1'b1;
    exp_q.push_back('{d, p});
    last = '{d, p};
    for (int k = 0; k < hi - 1; k++) begin
      @(negedge clk);
      chk(drive_en == '0, "R3 off while strobe high", drive_en, 0);
      if (scramble && k == 0) begin
        line_data = ~d; polarity = ~p;
      end
    end
    @(negedge clk);
    chk(drive_en == '0, "R3 off while strobe high", drive_en, 0);
    strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle_hold(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      line_data = {$urandom(), $urandom()};
      polarity  = ~polarity;
      chk(ch_code == last.codes, "R4 hold between pulses", ch_code, last.codes);
      chk(ch_lower[0] == last.pol, "R4 set held", ch_lower[0], last.pol);
      chk(&drive_en, "R4 stays driven", drive_en, {NCH{1'b1}});
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "R4 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [LW-1:0] d;
    rst_n = 1'b0; strobe = 1'b1; polarity = 1'b0; line_data = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drive_en == '0, "R1 reset enables", drive_en, 0);
    chk(ch_code == '0, "R1 reset codes", ch_code, 0);
    strobe = 1'b0; // fall without a rise seen after reset
    repeat (3) begin
      @(negedge clk);
      chk(drive_en == '0, "R1 partial pulse ignored", drive_en, 0);
      chk(ch_code == '0, "R1 codes untouched", ch_code, 0);
    end

    d = {6'h3F, 6'h3E, 6'h30, 6'h20, 6'h1F, 6'h10, 6'h0F, 6'h00};
    send_line(d, 1'b0, 3, 1'b0); idle_hold(4);
    send_line(d, 1'b1, 2, 1'b0); idle_hold(3);
    send_line({NCH{6'h3F}}, 1'b0, 2, 1'b0); idle_hold(2);
    send_line({NCH{6'h00}}, 1'b1, 2, 1'b0); idle_hold(2);
    // data and polarity disturbed while strobe high: rise-time values must win (R2, R5)
    send_line({6'h05, 6'h3A, 6'h21, 6'h17, 6'h2C, 6'h3F, 6'h08, 6'h11}, 1'b1, 4, 1'b1);
    idle_hold(2);
    for (int n = 0; n < 20; n++) begin
      send_line({$urandom(), $urandom()}, 1'($urandom()), 2 + (n % 3), 1'(n % 2));
      idle_hold(n % 3);
    end
    @(negedge clk);
    chk(exp_q.size() == 0, "R2 every line presented", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule